// File: doc/BRIEF.md
# Parity Generator and Checker with Shared Reduction Tree

This block computes single-bit parity over a data word, and can either produce a parity bit for transmission or test a received word against its parity bit. One balanced XOR reduction tree serves both jobs. A mode input decides two things: whether the received parity bit enters the tree as an extra leaf, and which registered output carries the result. A second select picks even or odd parity.

Each cycle with the input strobe high, the block samples its inputs. One clock later it presents the result together with an output strobe. When the strobe is low, the result registers keep their values. The data width is a parameter with a default of 8.

Top module: `parity_unit`

## Requirements
- R1: In generate mode (mode_i = 0) with even parity (odd_i = 0), parity_o equals the XOR of all bits of data_i, so the number of ones in data plus parity is even.
- R2: With odd_i = 1, the result is the inverse of the even result, in both generate and check mode.
- R3: In check mode (mode_i = 1) with even parity, err_o equals the XOR of all bits of data_i and rx_par_i, so 1 means the total count of ones is odd.
- R4: In check mode with odd parity, err_o is 1 exactly when the total count of ones in data_i and rx_par_i is even.
- R5: In check mode, a word with an even number of flipped bits relative to a correctly protected word gives err_o = 0.
- R6: In generate mode, rx_par_i has no effect on parity_o, and err_o is 0.
- R7: In check mode, parity_o is 0.
- R8: valid_o is valid_i delayed by one clock, and parity_o and err_o show the result for inputs sampled at the edge where valid_i was high.
- R9: At an edge where valid_i is low, parity_o and err_o keep their values.
- R10: While rst_ni is low, parity_o, err_o and valid_o are 0.
- R11: With a data width of 4: generating for 1011 gives even parity 1; checking 1011 with received parity 1 gives err_o 0; checking 1001 with received parity 1 gives err_o 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input strobe; inputs are sampled when high |
| mode_i | input | 1 | 0 = generate, 1 = check |
| odd_i | input | 1 | 0 = even parity, 1 = odd parity |
| data_i | input | DATA_W | Data word |
| rx_par_i | input | 1 | Received parity bit, used only in check mode |
| parity_o | output | 1 | Registered generated parity bit |
| err_o | output | 1 | Registered parity error flag |
| valid_o | output | 1 | Output strobe, one cycle after valid_i |

## Verification
The result path has a single register stage, so any fault shows at the ports on the first strobed cycle that reaches it. A missing or stuck tree leaf makes parity_o or err_o wrong for about half of all random words on that first cycle. Wrong gating of the received bit, or a wrong output select, appears on the first operation in the affected mode. A broken hold or strobe path shows on the first idle cycle after a result.

// File: rtl/parity_pkg.sv
package parity_pkg;
  typedef enum logic {
    PM_GEN   = 1'b0,
    PM_CHECK = 1'b1
  } par_mode_e;
endpackage

// File: rtl/parity_xor_tree.sv
// Balanced XOR reduction, heap layout: node k has children 2k+1 and 2k+2.
module parity_xor_tree #(
  parameter int unsigned N = 9
) (
  input  logic [N-1:0] leaf_i,
  output logic         root_o
);
  localparam int unsigned LVL   = (N > 1) ? $clog2(N) : 0;
  localparam int unsigned NPAD  = 1 << LVL;
  localparam int unsigned NODES = 2 * NPAD - 1;

  logic [NODES-1:0] node;

  for (genvar j = 0; j < NPAD; j++) begin : g_leaf
    if (j < N) begin : g_real
      assign node[NPAD-1+j] = leaf_i[j];
    end else begin : g_pad
      assign node[NPAD-1+j] = 1'b0;
    end
  end

  for (genvar k = 0; k < NPAD - 1; k++) begin : g_node
    assign node[k] = node[2*k+1] ^ node[2*k+2];
  end

  assign root_o = node[0];
endmodule

// File: rtl/parity_leaf_sel.sv
// Builds tree leaves; received parity enters only in check mode.
module parity_leaf_sel
  import parity_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  par_mode_e         mode_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              rx_par_i,
  output logic [DATA_W:0]   leaf_o
);
  always_comb begin
    leaf_o = {1'b0, data_i};
    if (mode_i == PM_CHECK) leaf_o[DATA_W] = rx_par_i;
  end
endmodule

// File: rtl/parity_out_stage.sv
module parity_out_stage
  import parity_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      valid_i,
  input  par_mode_e mode_i,
  input  logic      res_i,
  output logic      parity_o,
  output logic      err_o,
  output logic      valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      parity_o <= 1'b0;
      err_o    <= 1'b0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        parity_o <= (mode_i == PM_GEN)   ? res_i : 1'b0;
        err_o    <= (mode_i == PM_CHECK) ? res_i : 1'b0;
      end
    end
  end
endmodule

// File: rtl/parity_unit.sv
module parity_unit
  import parity_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              mode_i,
  input  logic              odd_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              rx_par_i,
  output logic              parity_o,
  output logic              err_o,
  output logic              valid_o
);
  localparam int unsigned LEAVES = DATA_W + 1;

  par_mode_e         mode;
  logic [LEAVES-1:0] leaf;
  logic              root;
  logic              res;

  assign mode = par_mode_e'(mode_i);

  parity_leaf_sel #(.DATA_W(DATA_W)) u_leaf (
    .mode_i  (mode),
    .data_i  (data_i),
    .rx_par_i(rx_par_i),
    .leaf_o  (leaf)
  );

  parity_xor_tree #(.N(LEAVES)) u_tree (
    .leaf_i(leaf),
    .root_o(root)
  );

  // Odd select inverts both generated bit and check verdict.
  assign res = root ^ odd_i;

  parity_out_stage u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .mode_i  (mode),
    .res_i   (res),
    .parity_o(parity_o),
    .err_o   (err_o),
    .valid_o (valid_o)
  );
endmodule

// File: rtl/parity_unit_chk.sv
module parity_unit_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              mode_i,
  input logic              odd_i,
  input logic [DATA_W-1:0] data_i,
  input logic              rx_par_i,
  input logic              parity_o,
  input logic              err_o,
  input logic              valid_o
);
  assert_valid_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_valid_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_gen_parity_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !mode_i) |=> (parity_o == $past((^data_i) ^ odd_i)));
  assert_check_err_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i) |=> (err_o == $past((^data_i) ^ rx_par_i ^ odd_i)));
  assert_gen_no_err_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !mode_i) |=> !err_o);
  assert_check_no_par_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i) |=> !parity_o);
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(parity_o) && $stable(err_o)));
  always_comb begin
    if (!rst_ni) assert_reset_R10: assert (!parity_o && !err_o && !valid_o);
  end
endmodule

bind parity_unit parity_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .mode_i  (mode_i),
  .odd_i   (odd_i),
  .data_i  (data_i),
  .rx_par_i(rx_par_i),
  .parity_o(parity_o),
  .err_o   (err_o),
  .valid_o (valid_o)
);

// File: tb/parity_unit_tb.sv
module parity_unit_tb;
  localparam int unsigned W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic         v8 = 0, m8 = 0, o8 = 0, r8 = 0;
  logic [W-1:0] d8 = '0;
  logic         p8, e8, vo8;
  logic         v4 = 0, m4 = 0, o4 = 0, r4 = 0;
  logic [3:0]   d4 = '0;
  logic         p4, e4, vo4;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  parity_unit #(.DATA_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(v8), .mode_i(m8), .odd_i(o8),
    .data_i(d8), .rx_par_i(r8), .parity_o(p8), .err_o(e8), .valid_o(vo8));

  parity_unit #(.DATA_W(4)) u_dut4 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(v4), .mode_i(m4), .odd_i(o4),
    .data_i(d4), .rx_par_i(r4), .parity_o(p4), .err_o(e4), .valid_o(vo4));

  function automatic logic ones_odd(input logic [W-1:0] d);
    int c = 0;
    for (int i = 0; i < W; i++) c += int'(d[i]);
    return logic'(c % 2);
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  logic last_p = 0, last_e = 0;

  // Drive at negedge, check one negedge later.
  task automatic op8(input logic md, input logic od, input logic [W-1:0] d,
                     input logic rp, input string req);
    logic ep, ee, tot;
    v8 = 1; m8 = md; o8 = od; d8 = d; r8 = rp;
    tot = ones_odd(d) ^ (md ? rp : 1'b0);
    ep = md ? 1'b0 : (tot ^ od);
    ee = md ? (tot ^ od) : 1'b0;
    @(negedge clk);
    v8 = 0;
    chk({req, " R8 valid"}, vo8, 1'b1);
    chk({req, " parity"}, p8, ep);
    chk({req, " err"}, e8, ee);
    last_p = ep; last_e = ee;
  endtask

  task automatic idle8(input logic [W-1:0] d);
    v8 = 0; d8 = d; r8 = ~r8; m8 = ~m8; o8 = ~o8;
    @(negedge clk);
    chk("R8 idle valid", vo8, 1'b0);
    chk("R9 hold parity", p8, last_p);
    chk("R9 hold err", e8, last_e);
  endtask

  task automatic op4(input logic md, input logic [3:0] d, input logic rp,
                     input logic ep, input logic ee, input string req);
    v4 = 1; m4 = md; o4 = 0; d4 = d; r4 = rp;
    @(negedge clk);
    v4 = 0;
    chk({req, " valid"}, vo4, 1'b1);
    chk({req, " parity"}, p4, ep);
    chk({req, " err"}, e4, ee);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R10 reset parity", p8, 1'b0);
    chk("R10 reset err", e8, 1'b0);
    chk("R10 reset valid", vo8, 1'b0);
    rst_n = 1;
    @(negedge clk);

    // Directed
    op8(0, 0, 8'hB4, 0, "R1 gen even 4 ones");
    op8(0, 0, 8'hB6, 1, "R1 gen even 5 ones, R6 rx ignored");
    op8(0, 1, 8'hB6, 0, "R2 gen odd");
    op8(0, 0, 8'h00, 1, "R6 gen zero word rx=1");
    op8(1, 0, 8'hB6, 1, "R3 check good");
    op8(1, 0, 8'hB7, 1, "R3 check single flip");
    op8(1, 0, 8'hB5, 1, "R5 check double flip undetected");
    op8(1, 1, 8'hB6, 0, "R4 check odd good");
    op8(1, 1, 8'hB6, 1, "R4 check odd even total");
    op8(1, 0, 8'hFF, 0, "R7 check all ones");
    idle8(8'h5A);
    idle8(8'hFF);

    // Width 4
    op4(0, 4'b1011, 1'b0, 1'b1, 1'b0, "R11 gen 1011");
    op4(1, 4'b1011, 1'b1, 1'b0, 1'b0, "R11 check 1011/1");
    op4(1, 4'b1001, 1'b1, 1'b0, 1'b1, "R11 check 1001/1");

    // Random
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] rd;
      rd = W'($urandom);
      if (($urandom % 5) == 0) idle8(rd);
      else op8(logic'($urandom), logic'($urandom), rd, logic'($urandom),
               "R1 R2 R3 R4 R6 R7 random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule